// File: doc/BRIEF.md
# Retention Quiescence Handshake Responder

This block is the device end of a four-wire quiescence handshake through which an external power controller may place a piece of logic into a state-retaining low-leakage condition. The local logic tells the block whether it is idle. The block counts timer ticks while that idle indication holds. Once a programmed number of ticks has elapsed, it drops an active hint so that the controller knows retention is worth trying.

The controller asks for quiescence by pulling an active-low request low. At that moment the block decides between two answers. It grants with an active-low accept when the logic is still idle and the idle delay has run out. Otherwise it refuses with an active-high deny. While the request and the grant are both held, the logic is quiescent. If new work arrives in that state, the idle indication falls and the active hint rises again to ask for an exit. Releasing the request completes the return leg of the handshake. The block also watches the controller and reports a request that falls before the previous answer has been withdrawn.

Top module: `qch_responder`

## Requirements
- R1: While reset is high, accept_n is 0, deny is 0 and the active hint is 1. After reset falls with the request high, accept_n stays 0 for one more clock edge and reads 1 after the second edge.
- R2: A tick is counted only on a cycle where idle and tick are both 1. The active hint falls one cycle after the edge that counts the tick bringing the count to the delay field value, and stays 0 while idle holds.
- R3: Any cycle with idle at 0 clears the tick count and sets the active hint to 1 on the next edge. Ticks that arrive while idle is 0 are not counted.
- R4: A request sampled low in the running state, while idle is 1 and the count has reached a nonzero delay field, drives accept_n to 0 on that edge with deny 0. Accept_n stays 0 for as long as the request stays low.
- R5: A request sampled low in the running state when that grant condition is false drives deny to 1 with accept_n at 1. Deny holds while the request stays low and returns to 0 on the edge that samples the request high.
- R6: A delay field of 0 keeps the active hint at 1 and makes every request receive deny.
- R7: Idle falling while in the quiescent state raises the active hint on the next edge. Accept_n stays 0 until the request is released.
- R8: After the request is sampled high in the quiescent state, accept_n stays 0 for one more edge and then returns to 1.
- R9: A request that falls (high on the previous sampled edge, low on this one) while accept_n is 0 or deny is 1 raises proto_err for exactly one cycle after that edge. A legal request leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_i | input | 1 | Local logic is idle |
| tick_i | input | 1 | Timer tick strobe |
| dly_i | input | DLY_W | Idle ticks required before retention; 0 disables retention |
| qreq_n_i | input | 1 | Quiescence request from the controller, active low |
| qactive_o | output | 1 | Active hint; low means retention is worth trying |
| qaccept_n_o | output | 1 | Grant, active low |
| qdeny_o | output | 1 | Refusal, active high |
| proto_err_o | output | 1 | One-cycle flag for a request that falls too early |

## Verification
The hardest case to reach is a request that arrives on the same edge as the idle indication drops, after the active hint has already fallen. Only the decision made at the request edge then separates a deny from an accept. The bench first brings the active hint down with a counted run of ticks. It then changes idle and the request in the same drive slot and checks that a deny comes back. A second hard case is a request that returns low during the one-cycle window in which accept is still held on the way out. The bench reaches it by releasing and re-asserting the request on adjacent cycles.

// File: rtl/qch_pkg.sv
package qch_pkg;

    typedef enum logic [1:0] {
        QS_RUN  = 2'd0,
        QS_STOP = 2'd1,
        QS_EXIT = 2'd2,
        QS_DENY = 2'd3
    } qstate_e;

    typedef struct packed {
        logic accept_n;
        logic deny;
    } qresp_t;

    function automatic qresp_t resp_of(qstate_e s);
        qresp_t r;
        r.accept_n = !(s == QS_STOP || s == QS_EXIT);
        r.deny     = (s == QS_DENY);
        return r;
    endfunction

endpackage

// File: rtl/qch_idle_timer.sv
module qch_idle_timer #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             ready_o,
    output logic             qactive_o
);
    localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};

    logic [DLY_W-1:0] cnt_q;
    logic             qactive_q;

    assign ready_o = idle_i && (dly_i != '0) && (cnt_q >= dly_i);

    always_ff @(posedge clk) begin
        if (rst || !idle_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) qactive_q <= 1'b1;
        else     qactive_q <= !ready_o;
    end

    assign qactive_o = qactive_q;

    // R3: idle dropping clears the count and raises the hint
    a_r3_idle_drop_clears: assert property (@(posedge clk) disable iff (rst)
        !idle_i |=> (cnt_q == '0) && qactive_q);

    // R2: the count never moves without a qualified tick
    a_r2_count_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (idle_i && !tick_i) |=> $stable(cnt_q));

    // R6: a zero delay never lets the hint fall
    a_r6_zero_keeps_active: assert property (@(posedge clk) disable iff (rst)
        (dly_i == '0) |=> qactive_q);

endmodule

// File: rtl/qch_fsm.sv
module qch_fsm
    import qch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   qreq_n_i,
    input  logic   ready_i,
    output qresp_t resp_o
);
    qstate_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            QS_RUN:  if (!qreq_n_i) st_d = ready_i ? QS_STOP : QS_DENY;
            QS_STOP: if (qreq_n_i)  st_d = QS_EXIT;
            QS_EXIT: st_d = QS_RUN;
            QS_DENY: if (qreq_n_i)  st_d = QS_RUN;
            default: st_d = QS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= QS_STOP;
        else     st_q <= st_d;
    end

    assign resp_o = resp_of(st_q);

    // R4: grant is held while the request stays low
    a_r4_accept_holds: assert property (@(posedge clk) disable iff (rst)
        (st_q == QS_STOP && !qreq_n_i) |=> !resp_o.accept_n);

    // R5: a request that is not ready is refused
    a_r5_busy_denied: assert property (@(posedge clk) disable iff (rst)
        (st_q == QS_RUN && !qreq_n_i && !ready_i) |=> resp_o.deny && resp_o.accept_n);

    // R5: deny clears once the request is released
    a_r5_deny_release: assert property (@(posedge clk) disable iff (rst)
        (st_q == QS_DENY && qreq_n_i) |=> !resp_o.deny);

    // R8: release from quiescence takes exactly one held cycle
    a_r8_exit_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (st_q == QS_STOP && qreq_n_i) |=> !resp_o.accept_n ##1 resp_o.accept_n);

endmodule

// File: rtl/qch_proto_mon.sv
module qch_proto_mon (
    input  logic clk,
    input  logic rst,
    input  logic qreq_n_i,
    input  logic accept_n_i,
    input  logic deny_i,
    output logic err_o
);
    logic req_prev_q;
    logic err_q;
    logic early_fall;

    assign early_fall = req_prev_q && !qreq_n_i && (!accept_n_i || deny_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_prev_q <= 1'b1;
            err_q      <= 1'b0;
        end else begin
            req_prev_q <= qreq_n_i;
            err_q      <= early_fall;
        end
    end

    assign err_o = err_q;

    // R9: the flag is a single-cycle pulse
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err_q && !early_fall |=> !err_q);

endmodule

// File: rtl/qch_responder.sv
module qch_responder
    import qch_pkg::*;
#(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_i,
    input  logic             tick_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             qreq_n_i,
    output logic             qactive_o,
    output logic             qaccept_n_o,
    output logic             qdeny_o,
    output logic             proto_err_o
);
    logic   ready;
    qresp_t resp;

    qch_idle_timer #(.DLY_W(DLY_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .idle_i    (idle_i),
        .tick_i    (tick_i),
        .dly_i     (dly_i),
        .ready_o   (ready),
        .qactive_o (qactive_o)
    );

    qch_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .qreq_n_i (qreq_n_i),
        .ready_i  (ready),
        .resp_o   (resp)
    );

    qch_proto_mon u_mon (
        .clk        (clk),
        .rst        (rst),
        .qreq_n_i   (qreq_n_i),
        .accept_n_i (resp.accept_n),
        .deny_i     (resp.deny),
        .err_o      (proto_err_o)
    );

    assign qaccept_n_o = resp.accept_n;
    assign qdeny_o     = resp.deny;

    // R6: a zero delay turns every request from the running state into a deny
    a_r6_zero_denies: assert property (@(posedge clk) disable iff (rst)
        (qaccept_n_o && !qdeny_o && !qreq_n_i && dly_i == '0) |=> qdeny_o);

    // R7: work during quiescence raises the hint but keeps the grant
    a_r7_work_in_stop: assert property (@(posedge clk) disable iff (rst)
        (!qaccept_n_o && !qreq_n_i && !idle_i) |=> qactive_o && !qaccept_n_o);

endmodule

// File: tb/qch_responder_tb.sv
module qch_responder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       idle_i, tick_i, qreq_n_i;
    logic [2:0] dly_i;
    logic       qactive_o, qaccept_n_o, qdeny_o, proto_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    qch_responder #(.DLY_W(3)) u_dut (
        .clk(clk), .rst(rst), .idle_i(idle_i), .tick_i(tick_i), .dly_i(dly_i),
        .qreq_n_i(qreq_n_i), .qactive_o(qactive_o), .qaccept_n_o(qaccept_n_o),
        .qdeny_o(qdeny_o), .proto_err_o(proto_err_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic pulse_tick();
        tick_i = 1'b1; cyc(1);
        tick_i = 1'b0; cyc(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_i = 1'b0; tick_i = 1'b0; qreq_n_i = 1'b1; dly_i = 3'd3;
        cyc(3);
        chk(qaccept_n_o, 1'b0, "R1 accept_n in reset");
        chk(qdeny_o,     1'b0, "R1 deny in reset");
        chk(qactive_o,   1'b1, "R1 active in reset");
        rst = 1'b0;
        cyc(1); chk(qaccept_n_o, 1'b0, "R1 accept_n one edge after reset");
        cyc(1); chk(qaccept_n_o, 1'b1, "R1 accept_n released");
    endtask

    task automatic t_timer();
        pulse_tick(); pulse_tick();               // idle low: ticks ignored
        idle_i = 1'b1; cyc(1);
        pulse_tick(); pulse_tick();
        chk(qactive_o, 1'b1, "R3 ticks while busy ignored / R2 two ticks");
        pulse_tick();
        chk(qactive_o, 1'b0, "R2 active falls after third tick");
    endtask

    task automatic t_accept_work_exit();
        qreq_n_i = 1'b0; cyc(1);
        chk(qaccept_n_o, 1'b0, "R4 accept granted");
        chk(qdeny_o,     1'b0, "R4 no deny with accept");
        cyc(3);
        chk(qaccept_n_o, 1'b0, "R4 accept held");
        chk(proto_err_o, 1'b0, "R9 legal request not flagged");
        idle_i = 1'b0; cyc(1);
        chk(qactive_o,   1'b1, "R7 active rises on work");
        chk(qaccept_n_o, 1'b0, "R7 accept kept during work");
        qreq_n_i = 1'b1; cyc(1);
        chk(qaccept_n_o, 1'b0, "R8 accept held one edge");
        cyc(1);
        chk(qaccept_n_o, 1'b1, "R8 accept released");
    endtask

    task automatic t_restart();
        idle_i = 1'b1; pulse_tick(); pulse_tick();
        idle_i = 1'b0; cyc(1);
        chk(qactive_o, 1'b1, "R3 active after idle drop");
        idle_i = 1'b1; pulse_tick(); pulse_tick();
        chk(qactive_o, 1'b1, "R3 count restarted");
        pulse_tick();
        chk(qactive_o, 1'b0, "R3 full delay reached again");
    endtask

    task automatic t_deny_busy();
        idle_i = 1'b0; qreq_n_i = 1'b0; cyc(1);
        chk(qdeny_o,     1'b1, "R5 deny when idle drops with request");
        chk(qaccept_n_o, 1'b1, "R5 no accept with deny");
        cyc(2);
        chk(qdeny_o, 1'b1, "R5 deny held");
        qreq_n_i = 1'b1; cyc(1);
        chk(qdeny_o, 1'b0, "R5 deny cleared on release");
    endtask

    task automatic t_zero_delay();
        dly_i = 3'd0; idle_i = 1'b1;
        for (int i = 0; i < 9; i++) pulse_tick();
        chk(qactive_o, 1'b1, "R6 active stays with zero delay");
        qreq_n_i = 1'b0; cyc(1);
        chk(qdeny_o,     1'b1, "R6 zero delay denies");
        chk(qaccept_n_o, 1'b1, "R6 zero delay no accept");
        qreq_n_i = 1'b1; cyc(1);
        chk(qdeny_o, 1'b0, "R6 deny cleared");
    endtask

    task automatic t_proto();
        dly_i = 3'd3; cyc(2);
        chk(qactive_o, 1'b0, "R2 ready with saturated count");
        qreq_n_i = 1'b0; cyc(1);
        chk(qaccept_n_o, 1'b0, "R9 setup accept");
        qreq_n_i = 1'b1; cyc(1);
        chk(qaccept_n_o, 1'b0, "R9 setup exit cycle");
        qreq_n_i = 1'b0; cyc(1);
        chk(proto_err_o, 1'b1, "R9 early request flagged");
        cyc(1);
        chk(proto_err_o, 1'b0, "R9 flag is one cycle");
        qreq_n_i = 1'b1; cyc(3);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_accept_work_exit();
        t_restart();
        t_deny_busy();
        t_zero_delay();
        t_proto();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule